// File: doc/BRIEF.md
# Early-Exit Radix-4 Sequential Multiplier

This block multiplies two 32-bit integers one two-bit multiplier digit per clock. The multiplier register shifts right by two places on every step, and the multiplicand register shifts left by two places. Each step adds one selected multiple of the shifted multiplicand into an accumulator. The run ends as soon as no multiplier bits that could still change the sum are left. A short multiplier therefore takes only a few cycles, and the latency depends on the operand data.

A one-cycle `start` loads the operands. `busy` covers the steps and `done` marks the last one. The result is the low 32 bits of the product, so signed and unsigned operands give the same answer. When `acc_en` is high, the accumulator starts at `addend` instead of zero, which makes this a multiply-accumulate.

A parameter chooses how each digit is formed. The default direct form selects 0, M, 2M or 3M. The recoded form selects 0, ±M or ±2M, and it carries a borrow bit into the next digit. That borrow can cost one extra step.

Top module: `r4_early_mul`

## Requirements
- R1: On the `done` cycle, `result` equals (op_a × op_b + (acc_en ? addend : 0)) mod 2^32. The operands are the values sampled with the accepted start.
- R2: A start seen while `busy` is low is accepted. `busy` goes high in the next cycle and stays high through every step. `done` is high for exactly one cycle, in the cycle where `busy` has just fallen.
- R3: A start asserted while `busy` is high is ignored. The running operation keeps its operands, its step count and its result.
- R4: `result` does not change from the `done` cycle until the next accepted start, whatever the other inputs do.
- R5: A multiplier of zero takes one step, so `done` is high two cycles after the accepted start.
- R6: In the direct form (BOOTH=0) the number of `busy` cycles is the smallest n ≥ 1 for which op_b >> 2n is zero. A multiplier below 256 therefore finishes in at most 4 steps, and a full-width multiplier needs 16.
- R7: In the recoded form (BOOTH=1) the number of `busy` cycles is the smallest n ≥ 1 for which op_b >> 2n is zero and bit 2n−1 of op_b is clear. A multiplier with bit 31 set needs 17.
- R8: When `acc_en` is low, `addend` has no effect on `result`.
- R9: While reset is held, and right after it is released, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a new multiply; ignored while busy |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier, consumed two bits per step |
| addend | input | 32 | Initial accumulator value when acc_en is high |
| acc_en | input | 1 | Selects multiply-accumulate |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when the result is final |
| result | output | 32 | Low 32 bits of the product plus optional addend |

## Verification
Two situations are hard to reach from the ports. The first is the recoded form's extra step, where the remaining multiplier is already zero but a borrow is still pending. The bench reaches it by sweeping every multiplier from 0 to 255 against several multiplicands, which covers every top-digit pattern. It also runs corner and random full-width multipliers with bit 31 set.

The second is a start that arrives in the middle of a run. The bench pulses `start` with different operands during long full-width runs. It then confirms that the step count and the result still match the first operation.

Both digit forms are instantiated side by side on the same inputs. For each operation the bench compares the step count and result of each form with values it computes arithmetically.

// File: rtl/r4m_pkg.sv
`timescale 1ns/1ps
package r4m_pkg;

   // Partial-product choice made for one two-bit multiplier digit
   typedef enum logic [2:0] {
      PP_ZERO = 3'd0,
      PP_POS1 = 3'd1,
      PP_POS2 = 3'd2,
      PP_POS3 = 3'd3,
      PP_NEG1 = 3'd4,
      PP_NEG2 = 3'd5
   } pp_sel_e;

endpackage

// File: rtl/r4m_recode.sv
`timescale 1ns/1ps
module r4m_recode
   import r4m_pkg::*;
#(
   parameter bit BOOTH = 1'b0
) (
   input  logic [1:0] pair,
   input  logic       cin,
   output pp_sel_e    sel,
   output logic       cout
);

   generate
      if (BOOTH) begin : g_booth
         // Digit value = -2*pair[1] + pair[0] + cin; the borrow is pair[1]
         always_comb begin
            case ({pair, cin})
               3'b001, 3'b010: sel = PP_POS1;
               3'b011:         sel = PP_POS2;
               3'b100:         sel = PP_NEG2;
               3'b101, 3'b110: sel = PP_NEG1;
               default:        sel = PP_ZERO;
            endcase
         end
         assign cout = pair[1];
      end else begin : g_direct
         // Plain unsigned digit 0..3, never any carry
         always_comb begin
            case (pair)
               2'b01:   sel = PP_POS1;
               2'b10:   sel = PP_POS2;
               2'b11:   sel = PP_POS3;
               default: sel = PP_ZERO;
            endcase
         end
         assign cout = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/r4m_ppgen.sv
`timescale 1ns/1ps
module r4m_ppgen
   import r4m_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter bit BOOTH = 1'b0
) (
   input  logic [WIDTH-1:0] mcand,
   input  pp_sel_e          sel,
   output logic [WIDTH-1:0] pp
);

   logic [WIDTH-1:0] m1;
   logic [WIDTH-1:0] m2;

   assign m1 = mcand;
   assign m2 = {mcand[WIDTH-2:0], 1'b0};

   generate
      if (BOOTH) begin : g_signed_mult
         always_comb begin
            case (sel)
               PP_POS1: pp = m1;
               PP_POS2: pp = m2;
               PP_NEG1: pp = (~m1) + 1'b1;
               PP_NEG2: pp = (~m2) + 1'b1;
               default: pp = '0;
            endcase
         end
      end else begin : g_triple_mult
         logic [WIDTH-1:0] m3;
         assign m3 = m1 + m2;
         always_comb begin
            case (sel)
               PP_POS1: pp = m1;
               PP_POS2: pp = m2;
               PP_POS3: pp = m3;
               default: pp = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/r4m_ctrl.sv
`timescale 1ns/1ps
module r4m_ctrl #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             last,
   output logic             load,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] iter
);

   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] iter_q;

   assign load = start & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         iter_q <= '0;
      end else begin
         done_q <= busy_q & last;
         if (load) begin
            busy_q <= 1'b1;
            iter_q <= '0;
         end else if (busy_q) begin
            iter_q <= iter_q + 1'b1;
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign iter = iter_q;

endmodule

// File: rtl/r4_early_mul.sv
`timescale 1ns/1ps
module r4_early_mul
   import r4m_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter bit BOOTH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] addend,
   input  logic             acc_en,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);

   localparam int MAX_IT = WIDTH / 2 + (BOOTH ? 1 : 0);
   localparam int CNT_W  = $clog2(MAX_IT + 1);

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("r4_early_mul: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] mc_q;
   logic [WIDTH-1:0] mp_q;
   logic             cy_q;
   logic [WIDTH-1:0] mp_nx;
   logic [WIDTH-1:0] pp;
   logic             cy_nx;
   logic             last;
   logic             load;
   logic [CNT_W-1:0] iter_cnt;
   pp_sel_e          sel;

   r4m_recode #(.BOOTH(BOOTH)) u_recode (
      .pair (mp_q[1:0]),
      .cin  (cy_q),
      .sel  (sel),
      .cout (cy_nx)
   );

   r4m_ppgen #(.WIDTH(WIDTH), .BOOTH(BOOTH)) u_ppgen (
      .mcand (mc_q),
      .sel   (sel),
      .pp    (pp)
   );

   assign mp_nx = mp_q >> 2;
   assign last  = (mp_nx == '0) && !cy_nx;

   r4m_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .last  (last),
      .load  (load),
      .busy  (busy),
      .done  (done),
      .iter  (iter_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         mc_q  <= '0;
         mp_q  <= '0;
         cy_q  <= 1'b0;
      end else if (load) begin
         acc_q <= addend & {WIDTH{acc_en}};
         mc_q  <= op_a;
         mp_q  <= op_b;
         cy_q  <= 1'b0;
      end else if (busy) begin
         acc_q <= acc_q + pp;
         mc_q  <= {mc_q[WIDTH-3:0], 2'b00};
         mp_q  <= mp_nx;
         cy_q  <= cy_nx;
      end
   end

   assign result = acc_q;

endmodule

// File: rtl/r4m_chk.sv
`timescale 1ns/1ps
module r4m_chk #(
   parameter int WIDTH  = 32,
   parameter int CNT_W  = 5,
   parameter int MAX_IT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] op_b,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] result,
   input logic [CNT_W-1:0] iter
);

   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R2
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R2
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (iter == $past(iter) + 1'b1)); // R3
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result)); // R4
   AST_ZERO_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_b == '0) |-> ##2 done); // R5
   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(iter) < MAX_IT)); // R6

endmodule

bind r4_early_mul r4m_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W), .MAX_IT(MAX_IT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .op_b   (op_b),
   .busy   (busy),
   .done   (done),
   .result (result),
   .iter   (iter_cnt)
);

// File: tb/r4_early_mul_tb.sv
`timescale 1ns/1ps
module r4_early_mul_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic         acc_en;
   logic [W-1:0] op_a, op_b, addend;
   logic         busy_d, done_d, busy_b, done_b;
   logic [W-1:0] res_d, res_b;
   int           checks = 0;
   int           errors = 0;

   always #2.5 clk = ~clk;

   r4_early_mul #(.WIDTH(W), .BOOTH(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .addend(addend), .acc_en(acc_en), .busy(busy_d), .done(done_d), .result(res_d));

   r4_early_mul #(.WIDTH(W), .BOOTH(1'b1)) u_dut_booth (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .addend(addend), .acc_en(acc_en), .busy(busy_b), .done(done_b), .result(res_b));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int it_direct(input logic [W-1:0] b);
      logic [2*W+3:0] bb;
      int n;
      bb = {{(W+4){1'b0}}, b};
      n = 1;
      while ((bb >> (2*n)) != 0) n++;
      return n;
   endfunction

   function automatic int it_booth(input logic [W-1:0] b);
      logic [2*W+3:0] bb;
      int n;
      bb = {{(W+4){1'b0}}, b};
      n = 1;
      while (((bb >> (2*n)) != 0) || bb[2*n-1]) n++;
      return n;
   endfunction

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] ad, input bit en, input bit poke);
      logic [W-1:0] expv;
      logic [W-1:0] rd, rb;
      int nd, nb;
      bit gd, gb;
      expv = a * b + (en ? ad : '0);
      nd = 0; nb = 0; gd = 0; gb = 0; rd = '0; rb = '0;
      @(negedge clk);
      op_a = a; op_b = b; addend = ad; acc_en = en; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 40 && !(gd && gb); i++) begin
         if (busy_d) nd++;
         if (busy_b) nb++;
         if (done_d && !gd) begin gd = 1; rd = res_d; end
         if (done_b && !gb) begin gb = 1; rb = res_b; end
         if (poke && i == 1) begin
            start = 1'b1; op_a = ~a; op_b = b ^ 32'h5a5a_0f0f; addend = ad + 1; acc_en = ~en;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(gd && gb, "R2 done pulse seen", {62'd0, gd, gb}, 64'd3);
      chk(rd == expv, poke ? "R3 result direct after mid-run start" : "R1 result direct", rd, expv);
      chk(rb == expv, poke ? "R3 result recoded after mid-run start" : "R1 result recoded", rb, expv);
      chk(nd == it_direct(b), poke ? "R3 steps direct after mid-run start" : "R6 steps direct", nd, it_direct(b));
      chk(nb == it_booth(b), poke ? "R3 steps recoded after mid-run start" : "R7 steps recoded", nb, it_booth(b));
      if (b < 256) chk(nd <= 4, "R6 8-bit multiplier within 4 steps", nd, 4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] corner [4];
      logic [W-1:0] hold;
      corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hffff_ffff; corner[3] = 32'h8000_0000;
      rst_n = 1'b0; start = 1'b0; acc_en = 1'b0; op_a = '0; op_b = '0; addend = '0;
      repeat (3) @(negedge clk);
      chk(!busy_d && !done_d && res_d == 0, "R9 reset state direct", {busy_d, done_d, res_d}, 0);
      chk(!busy_b && !done_b && res_b == 0, "R9 reset state recoded", {busy_b, done_b, res_b}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_d && !done_d && res_d == 0, "R9 idle after reset release", {busy_d, done_d, res_d}, 0);

      // R2 / R5: zero multiplier, cycle-exact handshake
      @(negedge clk);
      op_a = 32'h1234_5678; op_b = '0; addend = 32'h55; acc_en = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy_d && !done_d, "R2 busy one cycle after start", {busy_d, done_d}, 2);
      @(negedge clk);
      chk(!busy_d && done_d && res_d == 32'h55, "R5 zero multiplier done after one step", {busy_d, done_d, res_d}, {2'b01, 32'h55});
      @(negedge clk);
      chk(!done_d, "R2 done lasts one cycle", done_d, 0);

      // R8: addend ignored when accumulate is off
      run_op(32'h0000_0321, 32'h0000_0045, 32'hdead_beef, 1'b0, 1'b0);
      chk(res_d == 32'h0000_0321 * 32'h45, "R8 addend ignored", res_d, 32'h0000_0321 * 32'h45);

      // R4: result holds while other inputs move without start
      hold = res_d;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         op_a = $urandom; op_b = $urandom; addend = $urandom; acc_en = k[0];
      end
      @(negedge clk);
      chk(res_d == hold && res_b == hold, "R4 result stable until next start", res_d, hold);

      // Corner pairs
      foreach (corner[i]) foreach (corner[j]) run_op(corner[i], corner[j], 32'hffff_ffff, 1'b1, 1'b0);

      // R3: start pulsed mid-run with other operands
      run_op(32'h9abc_def1, 32'hffff_ffff, 32'h10, 1'b1, 1'b1);
      run_op(32'h8000_0001, 32'hc000_0003, 32'h0, 1'b0, 1'b1);

      // Near-exhaustive 8-bit multiplier sweep
      foreach (corner[i]) for (int b = 0; b < 256; b++)
         run_op(corner[i] ^ 32'h0000_0010, b, b * 32'h0101_0101, b[0], 1'b0);
      for (int b = 0; b < 256; b++) run_op(32'h1234_5678, b, 32'h7, b[1], 1'b0);

      // Random full and partial width operands
      for (int k = 0; k < 400; k++)
         run_op($urandom, $urandom >> ($urandom % 32), $urandom, k[0], 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule